// File: doc/BRIEF.md
# Banked GPIO Register Block

This block is a register file that controls a parameterised number of general-purpose pins, always a multiple of 32. Software reaches it over a simple word-addressed bus with an address, a write strobe, write data and registered read data. For each pin the block holds an output latch, a direction bit and a 2-bit alternate-function selector. It drives the pin output values, the output enables and the alternate-function selection. It also samples the pin inputs through a two-flop synchroniser.

Every register kind sits in its own bank of contiguous 32-bit words. A bank holds NREG = NPINS/32 words, and the banks follow one another in a fixed order. Outputs change only through two write-only words. A 1 written to the set word drives that pin high, and a 1 written to the clear word drives it low. Software therefore never needs a read-modify-write to change one pin's output.

There are three banks that would hold edge-detection settings. This block does no interrupt detection, so those banks are kept as reserved words. The alternate-function bank comes last and is twice as wide, because it packs 16 pins into each word. The default configuration is 96 pins, which gives 27 mapped words and a 5-bit address.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every direction bit, output latch and alternate-function field is 0, so `pin_oe`, `pin_out` and `pin_alt` are all zero and reads of those banks return 0.
- R2: The word address is kind*NREG + pin/32, with bit pin%32 inside the word. The kind indices are: level 0, direction 1, set 2, clear 3, reserved 4, 5 and 6, alternate function 7 (2*NREG words). Reserved words and addresses at or beyond 9*NREG read as 0, and writes to them change nothing.
- R3: A write to a set word drives high every pin whose data bit is 1. Pins whose data bit is 0 keep their output value.
- R4: A write to a clear word drives low every pin whose data bit is 1. Pins whose data bit is 0 keep their output value.
- R5: Set and clear words read back as 0.
- R6: Direction words can be read and written. Bit value 1 makes the pin an output, and `pin_oe` carries the direction bit of each pin.
- R7: A level read returns `pin_in` after a two-flop synchroniser. With the address held on a level word, a change of `pin_in` made before rising edge 1 first shows on `bus_rdata` after rising edge 3.
- R8: Writes to the level bank are ignored. No output, direction or alternate-function state changes.
- R9: The alternate-function field of pin p is 2 bits wide, at bits (p%16)*2 of word 7*NREG + p/16. The field can be read and written and appears on `pin_alt[2p+1:2p]`. The value 0 means plain GPIO.
- R10: `bus_rdata` is registered. It shows, after a rising edge, the contents of the word addressed just before that edge, including any write made at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (5) | Word address |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS (96) | Asynchronous pin inputs |
| pin_out | output | NPINS (96) | Output latch values |
| pin_oe | output | NPINS (96) | Output enables (direction bits) |
| pin_alt | output | 2*NPINS (192) | Alternate-function selector per pin |

## Verification
If the decoder points at the wrong bank or word, a readback one cycle after a write returns another word's value, or the wrong bits move on `pin_out`, `pin_oe` or `pin_alt` at the edge of the write. An output latch that merges set and clear data wrongly shows on `pin_out` at the next negative clock edge. This is checked with patterns that are partly set and partly left at zero. A synchroniser with the wrong depth shifts the first cycle on which a level read shows a new input. The bench therefore samples each of the three edges that follow the input change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int WORD_W = 32;
    localparam int AF_W   = 2;

    // Bank order on the bus; index times NREG gives the bank base word.
    typedef enum logic [3:0] {
        K_LEVEL = 4'd0,
        K_DIR   = 4'd1,
        K_SET   = 4'd2,
        K_CLR   = 4'd3,
        K_RSV0  = 4'd4,
        K_RSV1  = 4'd5,
        K_RSV2  = 4'd6,
        K_ALT   = 4'd7,
        K_NONE  = 4'd15
    } reg_kind_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NREG   = 3,
    parameter int ADDR_W = 5,
    parameter int IDX_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    localparam int ALT_BASE = 7 * NREG;
    localparam int WORDS    = 9 * NREG;

    always_comb begin
        kind = K_NONE;
        idx  = '0;
        if (int'(addr) < ALT_BASE) begin
            kind = reg_kind_e'(4'(int'(addr) / NREG));
            idx  = IDX_W'(int'(addr) % NREG);
        end else if (int'(addr) < WORDS) begin
            kind = K_ALT;
            idx  = IDX_W'(int'(addr) - ALT_BASE);
        end
    end
endmodule

// File: rtl/gpio_pin_word.sv
module gpio_pin_word
    import gpio_bank_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_dir,
    input  logic                   wr_set,
    input  logic                   wr_clr,
    input  logic                   wr_alt_lo,
    input  logic                   wr_alt_hi,
    input  logic [WORD_W-1:0]      wdata,
    output logic [WORD_W-1:0]      dir_q,
    output logic [WORD_W-1:0]      out_q,
    output logic [AF_W*WORD_W-1:0] alt_q
);
    logic [WORD_W-1:0] set_mask;
    logic [WORD_W-1:0] clr_mask;

    assign set_mask = wr_set ? wdata : '0;
    assign clr_mask = wr_clr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
            alt_q <= '0;
        end else begin
            if (wr_dir)
                dir_q <= wdata;
            out_q <= (out_q | set_mask) & ~clr_mask;
            if (wr_alt_lo)
                alt_q[WORD_W-1:0] <= wdata;
            if (wr_alt_hi)
                alt_q[AF_W*WORD_W-1:WORD_W] <= wdata;
        end
    end

    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((out_q & $past(wdata)) == $past(wdata)));                  // R3
    AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((out_q & $past(wdata)) == '0));                             // R4
    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_set && !wr_clr) |=> $stable(out_q));                               // R3
    AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));                                             // R6
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 96,
    parameter int ADDR_W = $clog2(9 * NPINS / 32)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NPINS-1:0]      pin_in,
    output logic [NPINS-1:0]      pin_out,
    output logic [NPINS-1:0]      pin_oe,
    output logic [2*NPINS-1:0]    pin_alt
);
    localparam int NREG  = NPINS / WORD_W;
    localparam int IDX_W = $clog2(2 * NREG);
    localparam int NSTB  = 5;

    reg_kind_e           dec_kind;
    logic [IDX_W-1:0]    dec_idx;
    logic [NPINS-1:0]    level_s;
    logic [NREG*NSTB-1:0] strobes;
    logic [WORD_W-1:0]   rd_next;

    gpio_in_sync #(.WIDTH(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (level_s)
    );

    gpio_addr_decode #(.NREG(NREG), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .addr (bus_addr),
        .kind (dec_kind),
        .idx  (dec_idx)
    );

    for (genvar w = 0; w < NREG; w++) begin : g_word
        logic s_dir, s_set, s_clr, s_alo, s_ahi;
        assign s_dir = bus_we && (dec_kind == K_DIR) && (dec_idx == IDX_W'(w));
        assign s_set = bus_we && (dec_kind == K_SET) && (dec_idx == IDX_W'(w));
        assign s_clr = bus_we && (dec_kind == K_CLR) && (dec_idx == IDX_W'(w));
        assign s_alo = bus_we && (dec_kind == K_ALT) && (dec_idx == IDX_W'(2 * w));
        assign s_ahi = bus_we && (dec_kind == K_ALT) && (dec_idx == IDX_W'(2 * w + 1));
        assign strobes[w*NSTB +: NSTB] = {s_dir, s_set, s_clr, s_alo, s_ahi};

        gpio_pin_word u_word (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_dir    (s_dir),
            .wr_set    (s_set),
            .wr_clr    (s_clr),
            .wr_alt_lo (s_alo),
            .wr_alt_hi (s_ahi),
            .wdata     (bus_wdata),
            .dir_q     (pin_oe[w*WORD_W +: WORD_W]),
            .out_q     (pin_out[w*WORD_W +: WORD_W]),
            .alt_q     (pin_alt[w*AF_W*WORD_W +: AF_W*WORD_W])
        );
    end

    always_comb begin
        rd_next = '0;
        unique case (dec_kind)
            K_LEVEL: rd_next = level_s[int'(dec_idx)*WORD_W +: WORD_W];
            K_DIR:   rd_next = pin_oe[int'(dec_idx)*WORD_W +: WORD_W];
            K_ALT:   rd_next = pin_alt[int'(dec_idx)*WORD_W +: WORD_W];
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else
            bus_rdata <= rd_next;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));                                                      // R2
    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_kind == K_SET || dec_kind == K_CLR) |=> (bus_rdata == '0));        // R5
    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_kind == K_RSV0 || dec_kind == K_RSV1 || dec_kind == K_RSV2 ||
         dec_kind == K_NONE) |=> (bus_rdata == '0));                             // R2
    AST_LEVEL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && dec_kind == K_LEVEL) |=>
        ($stable(pin_out) && $stable(pin_oe) && $stable(pin_alt)));              // R8
endmodule

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
    localparam int NP   = 96;
    localparam int NR   = NP / 32;
    localparam int AW   = 5;
    localparam int LVL  = 0;
    localparam int DIRB = 1 * NR;
    localparam int SETB = 2 * NR;
    localparam int CLRB = 3 * NR;
    localparam int RSVB = 4 * NR;
    localparam int ALTB = 7 * NR;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pin_in = '0;
    logic [NP-1:0]   pin_out;
    logic [NP-1:0]   pin_oe;
    logic [2*NP-1:0] pin_alt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    gpio_bank_regs #(.NPINS(NP), .ADDR_W(AW)) i_gpio_bank_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_alt   (pin_alt)
    );

    task automatic chk(input logic [2*NP-1:0] act, input logic [2*NP-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = AW'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    // Driver: present a read address and queue the expected word.
    task automatic rd(input int a, input logic [31:0] d, input string tag);
        exp_t it;
        @(negedge clk);
        bus_addr = AW'(a);
        bus_we   = 1'b0;
        it.data  = d;
        it.tag   = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: compare the queued word just after the edge that loads it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                chk({160'b0, bus_rdata}, {160'b0, it.data}, it.tag);
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] expo;
        logic [NP-1:0] pa;
        logic [NP-1:0] pb;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({96'b0, pin_out}, '0, "R1 pin_out after reset");
        chk({96'b0, pin_oe},  '0, "R1 pin_oe after reset");
        chk(pin_alt, '0, "R1 pin_alt after reset");
        chk({160'b0, bus_rdata}, '0, "R1 rdata after reset");
        rd(DIRB + 2, 32'h0, "R1 direction word 2 reads 0");
        rd(ALTB + 5, 32'h0, "R1 alt word 5 reads 0");

        // R6 direction
        wr(DIRB + 1, 32'hA5A5_0F0F);
        rd(DIRB + 1, 32'hA5A5_0F0F, "R6 direction readback");
        rd(DIRB + 0, 32'h0, "R6 neighbour direction word untouched");
        @(negedge clk);
        chk({96'b0, pin_oe}, {96'b0, 32'h0, 32'hA5A5_0F0F, 32'h0}, "R6 pin_oe follows direction");

        // R3 / R4 set and clear
        expo = '0;
        wr(SETB + 0, 32'h0000_00F3);
        expo[31:0] = 32'h0000_00F3;
        @(negedge clk);
        chk({96'b0, pin_out}, {96'b0, expo}, "R3 set drives ones high");
        wr(SETB + 0, 32'h0000_0100);
        expo[31:0] = 32'h0000_01F3;
        @(negedge clk);
        chk({96'b0, pin_out}, {96'b0, expo}, "R3 zero bits of set keep value");
        wr(CLRB + 0, 32'h0000_0003);
        expo[31:0] = 32'h0000_01F0;
        @(negedge clk);
        chk({96'b0, pin_out}, {96'b0, expo}, "R4 clear drives ones low");
        wr(SETB + 2, 32'hFFFF_FFFF);
        expo[95:64] = 32'hFFFF_FFFF;
        wr(CLRB + 2, 32'h0);
        @(negedge clk);
        chk({96'b0, pin_out}, {96'b0, expo}, "R4 zero clear word changes nothing");
        wr(CLRB + 2, 32'h8000_0001);
        expo[95:64] = 32'h7FFF_FFFE;
        @(negedge clk);
        chk({96'b0, pin_out}, {96'b0, expo}, "R4 clear edge bits of top word");

        // R5 write-only words
        rd(SETB + 0, 32'h0, "R5 set word reads 0");
        rd(CLRB + 2, 32'h0, "R5 clear word reads 0");

        // R7 level through synchroniser, steady
        pa = {32'hDEAD_BEEF, 32'h1234_5678, 32'h0F0F_F0F0};
        @(negedge clk);
        pin_in = pa;
        repeat (3) @(negedge clk);
        rd(LVL + 0, pa[31:0],  "R7 level word 0");
        rd(LVL + 1, pa[63:32], "R7 level word 1");
        rd(LVL + 2, pa[95:64], "R10 back-to-back level word 2");
        rd(DIRB + 1, 32'hA5A5_0F0F, "R10 back-to-back direction word 1");
        @(negedge clk);

        // R7 latency: change before edge 1, visible after edge 3
        pb = pa;
        pb[31:0] = 32'h5555_AAAA;
        @(negedge clk);
        bus_addr = AW'(LVL);
        @(negedge clk);
        pin_in = pb;
        @(posedge clk); #1;
        chk({160'b0, bus_rdata}, {160'b0, pa[31:0]}, "R7 old level after edge 1");
        @(posedge clk); #1;
        chk({160'b0, bus_rdata}, {160'b0, pa[31:0]}, "R7 old level after edge 2");
        @(posedge clk); #1;
        chk({160'b0, bus_rdata}, {160'b0, pb[31:0]}, "R7 new level after edge 3");

        // R8 level writes ignored
        wr(LVL + 0, 32'hFFFF_FFFF);
        @(negedge clk);
        chk({96'b0, pin_out}, {96'b0, expo}, "R8 level write leaves pin_out");
        chk({96'b0, pin_oe}, {96'b0, 32'h0, 32'hA5A5_0F0F, 32'h0}, "R8 level write leaves pin_oe");
        chk(pin_alt, '0, "R8 level write leaves pin_alt");
        rd(LVL + 0, pb[31:0], "R8 level still returns input");

        // R2 reserved and unmapped
        wr(RSVB + 0, 32'hFFFF_FFFF);
        wr(RSVB + 8, 32'hFFFF_FFFF);
        wr(27, 32'hFFFF_FFFF);
        wr(31, 32'hFFFF_FFFF);
        @(negedge clk);
        chk({96'b0, pin_out}, {96'b0, expo}, "R2 reserved writes leave pin_out");
        chk({96'b0, pin_oe}, {96'b0, 32'h0, 32'hA5A5_0F0F, 32'h0}, "R2 reserved writes leave pin_oe");
        chk(pin_alt, '0, "R2 reserved writes leave pin_alt");
        rd(RSVB + 0, 32'h0, "R2 reserved word reads 0");
        rd(RSVB + 8, 32'h0, "R2 last reserved word reads 0");
        rd(27, 32'h0, "R2 first unmapped address reads 0");
        rd(31, 32'h0, "R2 top address reads 0");

        // R9 alternate function
        wr(ALTB + 2, 32'h0000_0800);
        @(negedge clk);
        chk({190'b0, pin_alt[75:74]}, {190'b0, 2'd2}, "R9 pin 37 alt field");
        wr(ALTB + 5, 32'hC000_0000);
        @(negedge clk);
        chk({190'b0, pin_alt[191:190]}, {190'b0, 2'd3}, "R9 pin 95 alt field");
        chk({2'b0, pin_alt[189:0]}, {116'b0, 2'd2, 74'b0}, "R9 other alt fields stay 0");
        rd(ALTB + 2, 32'h0000_0800, "R9 alt word 2 readback");
        rd(ALTB + 5, 32'hC000_0000, "R9 alt word 5 readback");
        wr(ALTB + 0, 32'h0000_0001);
        @(negedge clk);
        chk({190'b0, pin_alt[1:0]}, {190'b0, 2'd1}, "R9 pin 0 alt field");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule